// File: doc/BRIEF.md
# Half-Rate DDR3 Command Timing Gate

This block sits between a command generator clocked at half the memory clock and a full-rate output stage. On each half-rate cycle the generator may offer one DDR3 command: activate, precharge, read, write, refresh or mode-register set. The gate holds the offer until every minimum spacing that earlier commands impose on that command type has elapsed. It then acknowledges the offer and issues the command for one half-rate cycle.

Each half-rate cycle covers two memory-clock slots. Every issued command carries a phase bit that tells the output stage which slot to use. This lets a spacing with an odd number of memory clocks be met exactly rather than rounded up. The timers all run on the half-rate clock. Each timer holds a remaining distance in memory clocks and loses two per cycle. A remainder of one means the command may go out in the second slot.

The gate also drives a two-bit write-data output-enable, one bit per slot, that frames each write burst of eight beats.

Top module: `halfRateCmdGate`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `reqAck`, `issueValid` and `wrOe` are 0. Reset clears all spacing history, so the first request after reset issues in slot 0 of the cycle that follows the edge that samples it.
- R2: A request is not acknowledged until every spacing imposed by the commands already issued is met. Once that holds, the request issues at the earliest legal memory clock. If the request is free to go when an edge samples it, it issues in the half-rate cycle right after that edge. The memory clock of an issue is 2*cycle + issuePhase.
- R3: Command codes are 0 activate, 1 precharge, 2 read, 3 write, 4 refresh and 5 mode-register set. `reqAck` is a one-cycle pulse and `issueValid` rises in the same cycle. `issueCmd` equals the code that was granted. A request still present in the cycle where `reqAck` is high is not granted again in the next cycle. Codes 6 and 7 are never acknowledged.
- R4: An odd spacing is met exactly. With a 5-clock activate-to-read spacing, a read offered right after an activate issues 5 memory clocks after it, with `issuePhase`=1, which selects the second slot.
- R5: The row spacings are as follows. From activate, read and write wait `pRcd`, precharge waits `pRas`, and another activate waits `pRas+pRp`. From precharge, activate, refresh and mode-register set each wait `pRp`.
- R6: The column spacings are as follows. Read to read and write to write wait `pCcd`. Read to write waits `pRtw` and write to read waits `pWtr`. Read to precharge waits `pRtp` and write to precharge waits `pWr`.
- R7: From refresh, activate, refresh and mode-register set each wait `pRfc`. From mode-register set, every command type waits `pMrd`.
- R8: Take a write issued at memory clock t. `wrOe` is high exactly in memory clocks t+pCwl-1 through t+pCwl+4, that is, one clock before and one clock after the four-clock burst. Bit 0 of `wrOe` is slot 0 and bit 1 is slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | A command is offered |
| reqCmd | input | 3 | Code of the offered command |
| reqAck | output | 1 | One-cycle grant pulse to the generator |
| issueValid | output | 1 | A command is issued this cycle |
| issueCmd | output | 3 | Code of the issued command |
| issuePhase | output | 1 | Slot of the issued command (0 first, 1 second) |
| wrOe | output | 2 | Write-data output enable per slot |

## Verification
The assertions assume that reset is held for at least one edge. They also assume that the generator keeps `reqCmd` stable while `reqValid` is high and it is waiting. The grant-legality checks then relate each grant to the timer state of the command it names.

The stimulus changes the request only on falling edges. It drops or replaces a request only after it sees `reqAck`, except in the deliberate hold scenario. That scenario keeps an acknowledged request one cycle longer to show it is not granted twice. The expected issue clock of each command comes from a model in the bench that records the issue time of every command type. The bench idles between write bursts so that each output-enable window can be checked alone.

// File: rtl/hrGatePkg.sv
package hrGatePkg;
  localparam int CMDW = 3;
  localparam int NCMD = 6;

  typedef enum logic [CMDW-1:0] {
    CMD_ACT = 3'd0,
    CMD_PRE = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_REF = 3'd4,
    CMD_MRS = 3'd5
  } cmdKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     grant;
    cmdKind_t cmd;
    logic     phase;
  } gateStrobe_t;
endpackage

// File: rtl/hrGateDatapath.sv
module hrGateDatapath
  import hrGatePkg::*;
#(
  parameter int pRcd = 5,
  parameter int pRp  = 5,
  parameter int pRas = 15,
  parameter int pWr  = 15,
  parameter int pRtp = 4,
  parameter int pRtw = 7,
  parameter int pWtr = 11,
  parameter int pCcd = 4,
  parameter int pRfc = 21,
  parameter int pMrd = 4,
  parameter int pCwl = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  gateStrobe_t     strobe,
  output logic [NCMD-1:0] readyNow,
  output logic [NCMD-1:0] readyLate,
  output logic [1:0]      wrOe
);

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXS = imax(imax(imax(pRas + pRp, pRfc), imax(pWr, pWtr)),
                             imax(imax(pRtw, pRcd),
                                  imax(imax(pCcd, pRtp), imax(pMrd, pRp))));
  localparam int TW  = $clog2(MAXS + 1);
  localparam int OEW = pCwl + 6;

  // memory clocks a command of kind src forces onto a later command of kind dst
  function automatic int spacingOf(cmdKind_t src, cmdKind_t dst);
    int s;
    s = 0;
    case (src)
      CMD_ACT: begin
        if (dst == CMD_RD || dst == CMD_WR) s = pRcd;
        else if (dst == CMD_PRE)            s = pRas;
        else if (dst == CMD_ACT)            s = pRas + pRp;
      end
      CMD_PRE: begin
        if (dst == CMD_ACT || dst == CMD_REF || dst == CMD_MRS) s = pRp;
      end
      CMD_RD: begin
        if (dst == CMD_RD)       s = pCcd;
        else if (dst == CMD_WR)  s = pRtw;
        else if (dst == CMD_PRE) s = pRtp;
      end
      CMD_WR: begin
        if (dst == CMD_WR)       s = pCcd;
        else if (dst == CMD_RD)  s = pWtr;
        else if (dst == CMD_PRE) s = pWr;
      end
      CMD_REF: begin
        if (dst == CMD_ACT || dst == CMD_REF || dst == CMD_MRS) s = pRfc;
      end
      CMD_MRS: s = pMrd;
      default: s = 0;
    endcase
    return s;
  endfunction

  // timer value counts memory clocks from slot 0 of the coming cycle
  function automatic logic [TW-1:0] nextTimer(logic [TW-1:0] cur, gateStrobe_t s,
                                              cmdKind_t dst);
    int dec;
    int rel;
    dec = (int'(cur) > 2) ? int'(cur) - 2 : 0;
    rel = s.grant ? spacingOf(s.cmd, dst) + int'(s.phase) - 2 : 0;
    if (rel > dec) dec = rel;
    return TW'(dec);
  endfunction

  logic [TW-1:0] timerArr [NCMD];

  for (genvar k = 0; k < NCMD; k++) begin : gTimer
    logic [TW-1:0] tq;

    always_ff @(posedge clk) begin
      if (rst) tq <= '0;
      else     tq <= nextTimer(tq, strobe, cmdKind_t'(k));
    end

    assign timerArr[k]  = tq;
    assign readyNow[k]  = (tq == '0);
    assign readyLate[k] = (tq <= TW'(1));

    // R5
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
      tq < TW'(MAXS));
  end

  // R2
  grant_legal_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.grant |-> (timerArr[strobe.cmd] <= TW'(strobe.phase)));

  // R4
  phase_late_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.grant && strobe.phase) |-> (timerArr[strobe.cmd] == TW'(1)));

  // write-data enable window, bit i = memory clock i counted from slot 0
  logic [OEW-1:0] oeWin;
  logic [OEW-1:0] oeMask;

  always_comb begin
    oeMask = '0;
    if (strobe.grant && strobe.cmd == CMD_WR) begin
      for (int b = 0; b < OEW; b++) begin
        if (b >= pCwl - 1 + int'(strobe.phase) && b <= pCwl + 4 + int'(strobe.phase))
          oeMask[b] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oeWin <= '0;
    else     oeWin <= (oeWin >> 2) | oeMask;
  end

  assign wrOe = oeWin[1:0];

endmodule

// File: rtl/hrGateControl.sv
module hrGateControl
  import hrGatePkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            reqValid,
  input  logic [CMDW-1:0] reqCmd,
  input  logic [NCMD-1:0] readyNow,
  input  logic [NCMD-1:0] readyLate,
  output gateStrobe_t     strobe,
  output logic            reqAck,
  output logic            issueValid,
  output logic [CMDW-1:0] issueCmd,
  output logic            issuePhase
);

  localparam int NCODE = 2 ** CMDW;

  logic [NCODE-1:0] nowAll;
  logic [NCODE-1:0] lateAll;
  logic             cmdKnown;

  assign nowAll   = {{(NCODE - NCMD){1'b0}}, readyNow};
  assign lateAll  = {{(NCODE - NCMD){1'b0}}, readyLate};
  assign cmdKnown = (reqCmd < CMDW'(NCMD));

  // a request seen while its ack is out is the one just granted
  always_comb begin
    strobe.grant = reqValid && !reqAck && cmdKnown && lateAll[reqCmd];
    strobe.cmd   = cmdKind_t'(reqCmd);
    strobe.phase = !nowAll[reqCmd];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqAck     <= 1'b0;
      issueValid <= 1'b0;
      issueCmd   <= '0;
      issuePhase <= 1'b0;
    end else begin
      reqAck     <= strobe.grant;
      issueValid <= strobe.grant;
      if (strobe.grant) begin
        issueCmd   <= reqCmd;
        issuePhase <= strobe.phase;
      end
    end
  end

  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reqAck |=> !reqAck);

  // R3
  ack_from_req_chk: assert property (@(posedge clk) disable iff (rst)
    reqAck |-> $past(reqValid));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!reqAck && !issueValid));

endmodule

// File: rtl/halfRateCmdGate.sv
module halfRateCmdGate
  import hrGatePkg::*;
#(
  parameter int pRcd = 5,
  parameter int pRp  = 5,
  parameter int pRas = 15,
  parameter int pWr  = 15,
  parameter int pRtp = 4,
  parameter int pRtw = 7,
  parameter int pWtr = 11,
  parameter int pCcd = 4,
  parameter int pRfc = 21,
  parameter int pMrd = 4,
  parameter int pCwl = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [2:0] reqCmd,
  output logic       reqAck,
  output logic       issueValid,
  output logic [2:0] issueCmd,
  output logic       issuePhase,
  output logic [1:0] wrOe
);

  gateStrobe_t     strobe;
  logic [NCMD-1:0] readyNow;
  logic [NCMD-1:0] readyLate;

  hrGateControl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .reqValid  (reqValid),
    .reqCmd    (reqCmd),
    .readyNow  (readyNow),
    .readyLate (readyLate),
    .strobe    (strobe),
    .reqAck    (reqAck),
    .issueValid(issueValid),
    .issueCmd  (issueCmd),
    .issuePhase(issuePhase)
  );

  hrGateDatapath #(
    .pRcd(pRcd), .pRp(pRp), .pRas(pRas), .pWr(pWr), .pRtp(pRtp), .pRtw(pRtw),
    .pWtr(pWtr), .pCcd(pCcd), .pRfc(pRfc), .pMrd(pMrd), .pCwl(pCwl)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .readyNow (readyNow),
    .readyLate(readyLate),
    .wrOe     (wrOe)
  );

endmodule

// File: tb/halfRateCmdGate_tb_top.sv
module halfRateCmdGate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RCD = 5, RP = 5, RAS = 15, WRR = 15, RTP = 4, RTW = 7;
  localparam int WTR = 11, CCD = 4, RFC = 21, MRD = 4, CWL = 5;
  localparam int ACT = 0, PRE = 1, RD = 2, WR = 3, REF = 4, MRS = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqValid = 1'b0;
  logic [2:0] reqCmd = 3'd0;
  logic       reqAck, issueValid, issuePhase;
  logic [2:0] issueCmd;
  logic [1:0] wrOe;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int lastAbs [6];
  int lastIssueCyc;

  halfRateCmdGate dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAck(reqAck), .issueValid(issueValid), .issueCmd(issueCmd),
    .issuePhase(issuePhase), .wrOe(wrOe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // spacing rules from R5, R6, R7
  function automatic int space(int src, int dst);
    case (src)
      ACT: return (dst == RD || dst == WR) ? RCD : (dst == PRE) ? RAS :
                  (dst == ACT) ? RAS + RP : 0;
      PRE: return (dst == ACT || dst == REF || dst == MRS) ? RP : 0;
      RD:  return (dst == RD) ? CCD : (dst == WR) ? RTW : (dst == PRE) ? RTP : 0;
      WR:  return (dst == WR) ? CCD : (dst == RD) ? WTR : (dst == PRE) ? WRR : 0;
      REF: return (dst == ACT || dst == REF || dst == MRS) ? RFC : 0;
      MRS: return MRD;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < 6; i++) lastAbs[i] = -100000;
    lastIssueCyc = -100000;
  endtask

  // offer a command, wait for the grant, compare its memory clock with the model
  task automatic doCmd(input int code, input string tag, input bit holdExtra,
                       output int issCyc, output int issPh);
    int k, earliest, minCyc, expAbs, guard;
    bit done;
    @(negedge clk);
    reqValid = 1'b1;
    reqCmd   = 3'(code);
    k = cyc;
    earliest = -100000;
    for (int s = 0; s < 6; s++)
      if (space(s, code) > 0 && lastAbs[s] + space(s, code) > earliest)
        earliest = lastAbs[s] + space(s, code);
    minCyc = (k + 1 > lastIssueCyc + 2) ? k + 1 : lastIssueCyc + 2;
    expAbs = (2 * minCyc > earliest) ? 2 * minCyc : earliest;
    done = 1'b0;
    guard = 0;
    while (!done && guard < 400) begin
      @(negedge clk);
      guard++;
      if (reqAck) done = 1'b1;
    end
    issCyc = cyc;
    issPh  = int'(issuePhase);
    check(done, {tag, " R2 grant arrives"}, int'(done), 1);
    check(issueValid == 1'b1, {tag, " R3 issueValid with ack"}, int'(issueValid), 1);
    check(int'(issueCmd) == code, {tag, " R3 issueCmd"}, int'(issueCmd), code);
    check(2 * issCyc + issPh == expAbs, {tag, " R2 issue clock"}, 2 * issCyc + issPh, expAbs);
    lastAbs[code] = expAbs;
    lastIssueCyc = issCyc;
    if (holdExtra) begin
      @(negedge clk);
      check(reqAck == 1'b0, {tag, " R3 held request not regranted"}, int'(reqAck), 0);
    end
    reqValid = 1'b0;
  endtask

  task automatic checkOe(input int issCyc, input int issPh, input string tag);
    int t, c;
    logic [1:0] e;
    t = 2 * issCyc + issPh;
    for (int j = 0; j < 8; j++) begin
      if (j > 0) @(negedge clk);
      c = issCyc + j;
      for (int s = 0; s < 2; s++)
        e[s] = (2 * c + s >= t + CWL - 1) && (2 * c + s <= t + CWL + 4);
      check(wrOe == e, {tag, " R8 wrOe window"}, int'(wrOe), int'(e));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tReset();
    rst = 1'b1;
    idle(3);
    check(reqAck == 1'b0 && issueValid == 1'b0, "R1 ack/issue low in reset",
          int'({reqAck, issueValid}), 0);
    check(wrOe == 2'b00, "R1 wrOe low in reset", int'(wrOe), 0);
    rst = 1'b0;
    clearModel();
    @(negedge clk);
    check(reqAck == 1'b0 && issueValid == 1'b0, "R1 quiet after reset",
          int'({reqAck, issueValid}), 0);
  endtask

  task automatic tOddSpacing();
    int c0, p0, c1, p1;
    doCmd(ACT, "R1 first act", 1'b0, c0, p0);
    check(p0 == 0, "R1 first command slot 0", p0, 0);
    doCmd(RD, "R4 act->rd", 1'b0, c1, p1);
    check(p1 == 1, "R4 odd spacing uses slot 1", p1, 1);
    check((2 * c1 + p1) - (2 * c0 + p0) == RCD, "R4 exact 5 clocks",
          (2 * c1 + p1) - (2 * c0 + p0), RCD);
  endtask

  task automatic tColumn();
    int c, p;
    doCmd(RD,  "R6 rd->rd", 1'b0, c, p);
    doCmd(WR,  "R6 rd->wr", 1'b0, c, p);
    doCmd(WR,  "R6 wr->wr", 1'b0, c, p);
    doCmd(RD,  "R6 wr->rd", 1'b0, c, p);
    doCmd(PRE, "R6 wr/rd->pre", 1'b0, c, p);
  endtask

  task automatic tRow();
    int c, p;
    doCmd(ACT, "R5 pre->act", 1'b0, c, p);
    doCmd(PRE, "R5 act->pre", 1'b0, c, p);
    doCmd(ACT, "R5 act->act", 1'b0, c, p);
    doCmd(WR,  "R5 act->wr", 1'b0, c, p);
    doCmd(PRE, "R5 wr->pre", 1'b0, c, p);
  endtask

  task automatic tRefresh();
    int c, p;
    doCmd(REF, "R7 pre->ref", 1'b0, c, p);
    doCmd(REF, "R7 ref->ref", 1'b0, c, p);
    doCmd(MRS, "R7 ref->mrs", 1'b0, c, p);
    doCmd(MRS, "R7 mrs->mrs", 1'b0, c, p);
    doCmd(ACT, "R7 mrs/ref->act", 1'b0, c, p);
  endtask

  task automatic tHandshake();
    int c, p;
    bit seen;
    idle(12);
    doCmd(PRE, "R3 hold", 1'b1, c, p);
    seen = 1'b0;
    @(negedge clk);
    reqValid = 1'b1;
    reqCmd   = 3'd6;
    repeat (8) begin
      @(negedge clk);
      if (reqAck) seen = 1'b1;
    end
    reqCmd = 3'd7;
    repeat (8) begin
      @(negedge clk);
      if (reqAck) seen = 1'b1;
    end
    check(!seen, "R3 codes 6/7 never acked", int'(seen), 0);
    reqValid = 1'b0;
  endtask

  task automatic tWriteOe();
    int c, p;
    idle(20);
    doCmd(WR, "R8 lone write", 1'b0, c, p);
    checkOe(c, p, "R8 slot0 write");
    idle(10);
    doCmd(ACT, "R8 act before write", 1'b0, c, p);
    doCmd(WR, "R8 odd write", 1'b0, c, p);
    check(p == 1, "R8 write in slot 1", p, 1);
    checkOe(c, p, "R8 slot1 write");
    idle(6);
  endtask

  task automatic tResetClears();
    int c, p;
    doCmd(REF, "R1 ref before reset", 1'b0, c, p);
    @(negedge clk);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    clearModel();
    doCmd(ACT, "R1 act right after reset", 1'b0, c, p);
    check(p == 0, "R1 timers cleared slot 0", p, 0);
  endtask

  initial begin
    clearModel();
    tReset();
    tOddSpacing();
    tColumn();
    tRow();
    tRefresh();
    tHandshake();
    tWriteOe();
    tResetClears();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule